// File: doc/BRIEF.md
# Single-Wire Bus Master Reset and Slot Sequencer

This block is the master side of a single-wire, open-drain bus with a pull-up. It turns one command into a timed waveform. A reset command holds the wire low for a long interval. It then releases the wire and checks, at a fixed point, whether a device is answering by pulling the wire low. Three short slot commands cover bit transfer. Write-zero holds the wire low for most of the slot. Write-one gives only a brief low and then leaves the wire released. Read gives a brief low, releases the wire, and samples the level a device leaves on it.

All timing comes from a one-microsecond tick input and fixed parameters. The block only drives a pull-down enable for the wire. It watches the wire through a small synchronizer chain. A client gives a two-bit command code with a one-cycle start strobe. It then waits for the one-cycle done pulse, after which the result bit is valid. The reset low time is limited by a ceiling derived from the bus-wide limit on low time. An oversized setting therefore cannot hide other devices' signalling.

Top module: `swBusMaster`

## Requirements
- R1: While reset is applied and just after it is released, busy, done, result and pullLow are all 0.
- R2: Command code 0 (bus reset) holds pullLow for RESET_LOW_US ticks (500 by default). It then releases the wire, and the operation ends RESET_RECV_US ticks (500) after the release.
- R3: For code 0, result is 1 exactly when the synchronized wire is low PRESENCE_SAMPLE_US ticks (70) after the release.
- R4: The reset low time in use is the smaller of RESET_LOW_US and LOW_LIMIT_US - RISE_US - 1. With the defaults 960 and 10 this is 949 ticks, so no pull-down run ever reaches LOW_LIMIT_US - RISE_US ticks.
- R5: Command code 1 (write zero) holds pullLow for 60 ticks and ends 70 ticks after the start, which leaves 10 ticks of recovery.
- R6: Command code 2 (write one) holds pullLow for 6 ticks and ends 70 ticks after the start.
- R7: Command code 3 (read) holds pullLow for 6 ticks and ends after 70 ticks. Result is the synchronized wire level 15 ticks after the start: 0 when a device holds the wire low, 1 when the wire is released.
- R8: Every operation ends with done high for exactly one cycle. Busy falls in that same cycle, and busy never falls without done.
- R9: A start strobe while busy is ignored. The running operation keeps its code and its timing, and no extra done appears.
- R10: An accepted start raises busy in the next cycle and pullLow in the cycle after that. pullLow is never high while busy is low.
- R11: The write commands (codes 1 and 2) clear result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle pulse each microsecond |
| cmdStart | input | 1 | Start strobe, accepted only while idle |
| cmdCode | input | 2 | 0 reset, 1 write zero, 2 write one, 3 read |
| lineIn | input | 1 | Raw wire level read back from the pad |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse at the end of an operation |
| result | output | 1 | Presence after a reset, sampled bit after a read, 0 after a write |
| pullLow | output | 1 | Open-drain pull-down enable for the wire |

## Verification
The main instance keeps the default timing of 500/500/70 ticks for reset and 70-tick slots. The tick is driven every fourth clock, so each full reset fits in a few thousand cycles while every phase boundary is still exercised exactly. A second instance uses RESET_LOW_US = 1200, which is above the ceiling. This brings the clamp into play and checks the reset low at 949 ticks. A behavioural device on the wire answers resets after 30 ticks for 120 ticks, holds the wire for zero reads, and samples writes 30 ticks into the slot.

// File: rtl/swBusPkg.sv
package swBusPkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'd0,
    OP_WRITE0 = 2'd1,
    OP_WRITE1 = 2'd2,
    OP_READ   = 2'd3
  } opCode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrCount;
    logic countEn;
    logic driveLow;
    logic capture;
    logic capInvert;
    logic clrResult;
  } dpStrobe_t;

endpackage

// File: rtl/swBusDatapath.sv
module swBusDatapath
  import swBusPkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickUs,
  input  logic             lineIn,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] usCount,
  output logic             pullLow,
  output logic             result
);

  logic lineSync;

  // wire synchronizer, idles at the released (high) level
  generate
    if (SYNC_STAGES < 2) begin : g_single
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= lineIn;
      end
      assign lineSync = syncQ;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
      assign lineSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // microsecond counter, relative to the start of the operation
  always_ff @(posedge clk) begin
    if (!rstN)                        usCount <= '0;
    else if (strobe.clrCount)         usCount <= '0;
    else if (strobe.countEn && tickUs) usCount <= usCount + 1'b1;
  end

  // registered pull-down enable: glitch-free pad drive
  always_ff @(posedge clk) begin
    if (!rstN) pullLow <= 1'b0;
    else       pullLow <= strobe.driveLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 result <= 1'b0;
    else if (strobe.clrResult) result <= 1'b0;
    else if (strobe.capture)   result <= strobe.capInvert ? ~lineSync : lineSync;
  end

endmodule

// File: rtl/swBusCtrl.sv
module swBusCtrl
  import swBusPkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int RST_LOW    = 500,
  parameter int RST_SAMPLE = 570,
  parameter int RST_END    = 1000,
  parameter int SLOT_END   = 70,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 6,
  parameter int RD_LOW     = 6,
  parameter int RD_SAMPLE  = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [1:0]       cmdCode,
  input  logic [CNT_W-1:0] usCount,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             done
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e           stateQ;
  opCode_e          opQ;
  logic             sampledQ;
  logic             doneQ;
  logic [CNT_W-1:0] lowEnd;
  logic [CNT_W-1:0] sampleAt;
  logic [CNT_W-1:0] slotEnd;
  logic             hasSample;
  logic             accept;
  logic             finish;

  // per-operation phase boundaries, counted from the start
  always_comb begin
    unique case (opQ)
      OP_RESET: begin
        lowEnd = CNT_W'(RST_LOW);  sampleAt = CNT_W'(RST_SAMPLE);
        slotEnd = CNT_W'(RST_END); hasSample = 1'b1;
      end
      OP_WRITE0: begin
        lowEnd = CNT_W'(W0_LOW);    sampleAt = '0;
        slotEnd = CNT_W'(SLOT_END); hasSample = 1'b0;
      end
      OP_WRITE1: begin
        lowEnd = CNT_W'(W1_LOW);    sampleAt = '0;
        slotEnd = CNT_W'(SLOT_END); hasSample = 1'b0;
      end
      default: begin
        lowEnd = CNT_W'(RD_LOW);    sampleAt = CNT_W'(RD_SAMPLE);
        slotEnd = CNT_W'(SLOT_END); hasSample = 1'b1;
      end
    endcase
  end

  assign accept = (stateQ == ST_IDLE) && cmdStart;
  assign finish = (stateQ == ST_RUN) && (usCount == slotEnd);

  always_comb begin
    strobe.clrCount  = accept;
    strobe.countEn   = (stateQ == ST_RUN);
    strobe.driveLow  = (stateQ == ST_RUN) && (usCount < lowEnd);
    strobe.capture   = (stateQ == ST_RUN) && hasSample && !sampledQ && (usCount == sampleAt);
    strobe.capInvert = (opQ == OP_RESET);
    strobe.clrResult = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      opQ      <= OP_RESET;
      sampledQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= finish;
      if (accept) begin
        stateQ   <= ST_RUN;
        opQ      <= opCode_e'(cmdCode);
        sampledQ <= 1'b0;
      end else begin
        if (finish)         stateQ   <= ST_IDLE;
        if (strobe.capture) sampledQ <= 1'b1;
      end
    end
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;

endmodule

// File: rtl/swBusMaster.sv
module swBusMaster
  import swBusPkg::*;
#(
  parameter int RESET_LOW_US       = 500,
  parameter int RESET_RECV_US      = 500,
  parameter int PRESENCE_SAMPLE_US = 70,
  parameter int LOW_LIMIT_US       = 960,
  parameter int RISE_US            = 10,
  parameter int SLOT_US            = 70,
  parameter int W0_LOW_US          = 60,
  parameter int W1_LOW_US          = 6,
  parameter int RD_LOW_US          = 6,
  parameter int RD_SAMPLE_US       = 15,
  parameter int SYNC_STAGES        = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       cmdStart,
  input  logic [1:0] cmdCode,
  input  logic       lineIn,
  output logic       busy,
  output logic       done,
  output logic       result,
  output logic       pullLow
);

  localparam int RST_LOW_CAP = LOW_LIMIT_US - RISE_US - 1;
  localparam int RST_LOW_EFF = (RESET_LOW_US > RST_LOW_CAP) ? RST_LOW_CAP : RESET_LOW_US;
  localparam int RST_END     = RST_LOW_EFF + RESET_RECV_US;
  localparam int MAX_COUNT   = (RST_END > SLOT_US) ? RST_END : SLOT_US;
  localparam int CNT_W       = $clog2(MAX_COUNT + 2);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] usCount;

  swBusCtrl #(
    .CNT_W      (CNT_W),
    .RST_LOW    (RST_LOW_EFF),
    .RST_SAMPLE (RST_LOW_EFF + PRESENCE_SAMPLE_US),
    .RST_END    (RST_END),
    .SLOT_END   (SLOT_US),
    .W0_LOW     (W0_LOW_US),
    .W1_LOW     (W1_LOW_US),
    .RD_LOW     (RD_LOW_US),
    .RD_SAMPLE  (RD_SAMPLE_US)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdCode  (cmdCode),
    .usCount  (usCount),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  swBusDatapath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickUs  (tickUs),
    .lineIn  (lineIn),
    .strobe  (strobe),
    .usCount (usCount),
    .pullLow (pullLow),
    .result  (result)
  );

endmodule

// File: rtl/swBusMasterChk.sv
module swBusMasterChk #(
  parameter int LOW_LIMIT_US = 960,
  parameter int RISE_US      = 10
) (
  input logic clk,
  input logic rstN,
  input logic tickUs,
  input logic cmdStart,
  input logic busy,
  input logic done,
  input logic pullLow
);

  localparam int LOW_CAP = LOW_LIMIT_US - RISE_US;

  // length of the current pull-down run, in ticks
  logic [15:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN)                            lowRun <= '0;
    else if (!pullLow)                    lowRun <= '0;
    else if (tickUs && lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
  end

  p_low_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    lowRun < 16'(LOW_CAP));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_fall_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_pull_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !busy) |=> busy ##1 pullLow);

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pullLow);

endmodule

bind swBusMaster swBusMasterChk #(
  .LOW_LIMIT_US (LOW_LIMIT_US),
  .RISE_US      (RISE_US)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickUs   (tickUs),
  .cmdStart (cmdStart),
  .busy     (busy),
  .done     (done),
  .pullLow  (pullLow)
);

// File: tb/swBusMaster_tb_top.sv
module swBusMaster_tb_top;

  localparam int EXP_RST_LOW   = 500;
  localparam int EXP_RST_SPAN  = 1000;
  localparam int EXP_SLOT      = 70;
  localparam int EXP_W0_LOW    = 60;
  localparam int EXP_SHORT_LOW = 6;
  localparam int EXP_CLAMP_LOW = 949;

  typedef struct {
    int   code;
    logic expResult;
    int   expLow;
    int   expSpan;
    logic expBit;
  } expItem_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic [1:0] tickPh = 2'd0;
  logic       tickUs;
  always @(posedge clk) tickPh <= tickPh + 2'd1;
  assign tickUs = (tickPh == 2'd3);

  logic       cmdStart = 1'b0;
  logic [1:0] cmdCode = 2'd0;
  logic       busy, done, result, dutPull, lineIn, devPull;

  logic       clampStart = 1'b0;
  logic       clampBusy, clampDone, clampResult, clampPull;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];
  int doneTotal = 0;

  // behavioural device on the wire
  logic devPresent = 1'b0, devIsRead = 1'b0, devReadBit = 1'b1;
  logic pullPrev, presArm, slotArm, gotBit, gotValid;
  int   lowCnt, relCnt, slotCnt, busyTicks, clampLow, clampTicks;

  assign devPull = (presArm && devPresent && relCnt >= 30 && relCnt < 150) ||
                   (slotArm && devIsRead && !devReadBit && slotCnt < 30);
  assign lineIn  = !(dutPull || devPull);

  always @(posedge clk) begin
    if (!rstN) begin
      pullPrev <= 1'b0; presArm <= 1'b0; slotArm <= 1'b0;
      gotBit <= 1'b0; gotValid <= 1'b0;
      lowCnt <= 0; relCnt <= 0; slotCnt <= 0;
    end else begin
      pullPrev <= dutPull;
      if (dutPull && !pullPrev) begin
        lowCnt <= 0; slotCnt <= 0; slotArm <= 1'b1; presArm <= 1'b0; gotValid <= 1'b0;
      end else if (tickUs) begin
        if (dutPull) lowCnt <= lowCnt + 1;
        slotCnt <= slotCnt + 1;
        relCnt  <= relCnt + 1;
        if (slotArm && slotCnt == 30 && !devIsRead && !gotValid) begin
          gotBit <= lineIn; gotValid <= 1'b1;
        end
      end
      if (!dutPull && pullPrev && lowCnt >= 480) begin
        presArm <= 1'b1; relCnt <= 0; slotArm <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (cmdStart && !busy)   busyTicks <= 0;
    else if (busy && tickUs) busyTicks <= busyTicks + 1;
    if (clampStart && !clampBusy) begin clampLow <= 0; clampTicks <= 0; end
    else if (tickUs) begin
      if (clampPull) clampLow <= clampLow + 1;
      if (clampBusy) clampTicks <= clampTicks + 1;
    end
  end

  swBusMaster dut_i (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .cmdStart(cmdStart), .cmdCode(cmdCode),
    .lineIn(lineIn), .busy(busy), .done(done), .result(result), .pullLow(dutPull)
  );

  swBusMaster #(.RESET_LOW_US(1200)) clamp_i (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .cmdStart(clampStart), .cmdCode(2'd0),
    .lineIn(!clampPull), .busy(clampBusy), .done(clampDone), .result(clampResult),
    .pullLow(clampPull)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkNear(input string req, input int act, input int exp);
    chk(act >= exp - 1 && act <= exp + 1, req, act, exp);
  endtask

  function automatic string lowTag(input int code);
    case (code)
      0: return "R2 reset low";
      1: return "R5 write0 low";
      2: return "R6 write1 low";
      default: return "R7 read low";
    endcase
  endfunction

  function automatic string resTag(input int code);
    case (code)
      0: return "R3 presence";
      3: return "R7 read bit";
      default: return "R11 write clears result";
    endcase
  endfunction

  // monitor: pops the scoreboard on every done
  logic prevDone = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (prevDone) chk(!done, "R8 done width", done, 0);
      prevDone = done;
      if (done) begin
        doneTotal++;
        chk(!busy, "R8 busy falls with done", busy, 0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(result == it.expResult, resTag(it.code), result, it.expResult);
          chkNear(lowTag(it.code), lowCnt, it.expLow);
          chkNear(it.code == 0 ? "R2 reset span" : "R5 R6 R7 slot span", busyTicks, it.expSpan);
          if (it.code == 1 || it.code == 2)
            chk(gotValid && gotBit == it.expBit, it.code == 1 ? "R5 bit seen" : "R6 bit seen",
                gotBit, it.expBit);
        end
      end
    end
  end

  // driver: one operation; noiseAt > 0 injects a start strobe while busy
  task automatic runOp(input int code, input logic present, input logic rdBit, input int noiseAt);
    expItem_t it;
    int n;
    devPresent = present;
    devIsRead  = (code == 3);
    devReadBit = rdBit;
    it.code = code;
    it.expResult = (code == 0) ? present : (code == 3) ? rdBit : 1'b0;
    it.expLow  = (code == 0) ? EXP_RST_LOW : (code == 1) ? EXP_W0_LOW : EXP_SHORT_LOW;
    it.expSpan = (code == 0) ? EXP_RST_SPAN : EXP_SLOT;
    it.expBit  = (code == 2);
    expQ.push_back(it);
    cmdCode  = 2'(code);
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    chk(busy, "R10 busy after start", busy, 1);
    @(negedge clk);
    chk(dutPull, "R10 pull after start", dutPull, 1);
    n = 2;
    while (busy || expQ.size() != 0) begin
      if (noiseAt != 0 && n == noiseAt) begin
        cmdCode = 2'd3; cmdStart = 1'b1;
      end else begin
        cmdStart = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    cmdStart = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!busy && !done && !dutPull && !result, "R1 state in reset", {busy, done, dutPull, result}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !dutPull && !result, "R1 state after reset", {busy, done, dutPull, result}, 0);

    runOp(0, 1'b1, 1'b1, 0);   // R2 R3 device present
    runOp(0, 1'b0, 1'b1, 0);   // R3 nobody answers
    runOp(1, 1'b0, 1'b1, 0);   // R5
    runOp(2, 1'b0, 1'b1, 0);   // R6
    runOp(3, 1'b0, 1'b0, 0);   // R7 device sends zero
    runOp(3, 1'b0, 1'b1, 0);   // R7 device sends one
    runOp(2, 1'b0, 1'b1, 0);   // R11 write clears the 1 left by the read
    runOp(3, 1'b0, 1'b1, 0);
    runOp(1, 1'b0, 1'b1, 100); // R9 read strobe injected mid write-zero
    chk(doneTotal == 9, "R9 done count", doneTotal, 9);
    chk(result == 1'b0, "R9 result after ignored read", result, 0);

    // R4 clamp on the oversized instance
    clampStart = 1'b1;
    @(negedge clk);
    clampStart = 1'b0;
    while (!clampDone) @(negedge clk);
    chkNear("R4 clamped low", clampLow, EXP_CLAMP_LOW);
    chk(clampLow < 950, "R4 below limit", clampLow, 949);
    chkNear("R4 clamped span", clampTicks, EXP_CLAMP_LOW + 500);
    chk(clampResult == 1'b0, "R4 no presence on empty wire", clampResult, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule